// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits between an internal request source and an 8-bit asynchronous NAND flash bus. A request is one of three things: a single command opcode, a group of address bytes, or one byte of program data. The sequencer turns each request into bus cycles by setting the chip-select, command-qualifier, address-qualifier and read-strobe levels, and by producing a write strobe pulse for each byte. Every pulse is timed in system clock cycles by a setup counter, a strobe-low counter and a strobe-high counter.

A program burst is a series of data requests issued back to back. A command request can carry a wait flag, which is used for confirm opcodes such as program or erase. When the flag is set, the sequencer waits a programmable minimum delay after the last strobe. It then watches the synchronized, wired-AND ready/busy line and reports completion only when that line has returned high. A data request that arrives before any command has been issued since reset is refused and flagged.

Top module: `nand_bus_seq`

## Requirements
- R1: A command request (`req_kind` = 0) produces exactly one write-strobe pulse. During that pulse chip select is low, the command qualifier is high, the address qualifier is low, the read strobe is high, and the I/O byte equals `req_byte`.
- R2: An address request (`req_kind` = 1) produces N_ADDR (default 4) consecutive strobe pulses. During each pulse the address qualifier is high, the command qualifier is low and chip select is low. The bytes of `req_addr` go out least significant byte first.
- R3: A data request (`req_kind` = 2 or 3) produces one strobe pulse with both qualifiers low and the I/O byte equal to `req_byte`.
- R4: Every write-strobe low phase lasts exactly T_WLOW clock cycles. The I/O byte and the qualifiers do not change while the strobe is low, and they are still driven in the cycle the strobe rises.
- R5: Before the first pulse of a request, the byte and qualifiers are driven for exactly T_SETUP cycles with the strobe high. Between the pulses of an address group, that high interval lasts T_WHIGH + T_SETUP cycles.
- R6: The I/O output enable is high only while chip select is low. The write strobe is low only while the output enable is high. Both are inactive when the block is idle.
- R7: `req_ready` is high only in idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. No request is taken while a bus cycle is in progress.
- R8: If a data request arrives before any command has been issued since reset, it is consumed. `err` pulses for one cycle, and no strobe pulse or chip select occurs.
- R9: For a command with `req_wait` set, `done` pulses T_WHIGH + T_BUSY_DLY + 1 cycles after the strobe rises if ready/busy is already high. If ready/busy is low, `done` stays low until the line returns high, and then pulses 3 cycles after the rise, because of the two synchronizer stages.
- R10: For a request without waiting, `done` pulses for one cycle, T_WHIGH cycles after the last strobe rise.
- R11: After reset, chip select, the write strobe and the read strobe are high. Both qualifiers, the output enable, `done` and `err` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_kind | input | 2 | 0 command, 1 address group, 2/3 data byte |
| req_byte | input | 8 | Opcode or program data byte |
| req_addr | input | 8*N_ADDR | Address bytes, least significant sent first |
| req_wait | input | 1 | Command only: wait for ready/busy before done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for data before any command |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command qualifier |
| nand_ale | output | 1 | Address qualifier |
| nand_we_n | output | 1 | Write strobe, byte captured on rising edge |
| nand_re_n | output | 1 | Read strobe, held high |
| nand_io_out | output | 8 | Byte driven to the I/O lines |
| nand_io_oe | output | 1 | I/O driver enable |
| nand_rdy | input | 1 | Wired-AND ready/busy, low = busy |

## Verification
The embedded assertions check these rules on every cycle: the qualifier pairing during each strobe, the stable byte and qualifiers across the low phase and the rising edge, the upper bound on strobe-low length, the coupling between output enable and chip select, the ready signal staying low during bus activity, and the absence of bus activity when an error is flagged. The following can only be shown by the bench scenarios: exact pulse counts per request, the order of address bytes, exact setup and inter-pulse gaps, and the completion latency with and without a busy interval. The bench sweeps every command opcode, several address patterns and a data burst.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WLOW,
    ST_WHIGH,
    ST_WDLY,
    ST_WRDY
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nbs_sync.sv
module nbs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nbs_timer.sv
module nbs_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int unsigned N_ADDR      = 4,
  parameter int unsigned T_SETUP     = 1,
  parameter int unsigned T_WLOW      = 2,
  parameter int unsigned T_WHIGH     = 2,
  parameter int unsigned T_BUSY_DLY  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_kind,
  input  logic [7:0]            req_byte,
  input  logic [8*N_ADDR-1:0]   req_addr,
  input  logic                  req_wait,
  output logic                  done,
  output logic                  err,
  output logic                  nand_ce_n,
  output logic                  nand_cle,
  output logic                  nand_ale,
  output logic                  nand_we_n,
  output logic                  nand_re_n,
  output logic [7:0]            nand_io_out,
  output logic                  nand_io_oe,
  input  logic                  nand_rdy
);
  localparam int unsigned ADDR_W = 8 * N_ADDR;
  localparam int unsigned T_MAX  = max2(max2(T_SETUP, T_WLOW), max2(T_WHIGH, T_BUSY_DLY));
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);
  localparam int unsigned IDX_W  = $clog2(N_ADDR + 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_WLOW  = CNT_W'(T_WLOW - 1);
  localparam logic [CNT_W-1:0] LD_WHIGH = CNT_W'(T_WHIGH - 1);
  localparam logic [CNT_W-1:0] LD_DLY   = CNT_W'(T_BUSY_DLY - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  left_q, left_d;
  logic              is_cmd_q, is_cmd_d;
  logic              is_addr_q, is_addr_d;
  logic              wait_q, wait_d;
  logic              has_cmd_q, has_cmd_d;
  logic              done_d, err_d, bus_act_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              rdy_s;

  nbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (nand_rdy),
    .q   (rdy_s)
  );

  nbs_timer #(.W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign nand_re_n = 1'b1;

  always_comb begin
    state_d   = state_q;
    sh_d      = sh_q;
    left_d    = left_q;
    is_cmd_d  = is_cmd_q;
    is_addr_d = is_addr_q;
    wait_d    = wait_q;
    has_cmd_d = has_cmd_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_kind[1] && !has_cmd_q) begin
            err_d = 1'b1;
          end else begin
            state_d   = ST_SETUP;
            tmr_load  = 1'b1;
            tmr_val   = LD_SETUP;
            is_cmd_d  = (req_kind == KIND_CMD);
            is_addr_d = (req_kind == KIND_ADDR);
            wait_d    = (req_kind == KIND_CMD) && req_wait;
            if (req_kind == KIND_CMD) has_cmd_d = 1'b1;
            if (req_kind == KIND_ADDR) begin
              left_d = IDX_W'(N_ADDR - 1);
              sh_d   = req_addr;
            end else begin
              left_d = '0;
              sh_d   = ADDR_W'(req_byte);
            end
          end
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_WLOW;
          tmr_load = 1'b1;
          tmr_val  = LD_WLOW;
        end
      end
      ST_WLOW: begin
        if (tmr_zero) begin
          state_d  = ST_WHIGH;
          tmr_load = 1'b1;
          tmr_val  = LD_WHIGH;
        end
      end
      ST_WHIGH: begin
        if (tmr_zero) begin
          if (left_q != '0) begin
            left_d   = left_q - 1'b1;
            sh_d     = sh_q >> 8;
            state_d  = ST_SETUP;
            tmr_load = 1'b1;
            tmr_val  = LD_SETUP;
          end else if (wait_q) begin
            state_d  = ST_WDLY;
            tmr_load = 1'b1;
            tmr_val  = LD_DLY;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_WDLY: begin
        if (tmr_zero) state_d = ST_WRDY;
      end
      ST_WRDY: begin
        if (rdy_s) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    bus_act_d = (state_d == ST_SETUP) || (state_d == ST_WLOW) || (state_d == ST_WHIGH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      left_q      <= '0;
      is_cmd_q    <= 1'b0;
      is_addr_q   <= 1'b0;
      wait_q      <= 1'b0;
      has_cmd_q   <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      nand_ce_n   <= 1'b1;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_we_n   <= 1'b1;
      nand_io_oe  <= 1'b0;
      nand_io_out <= '0;
    end else begin
      state_q     <= state_d;
      sh_q        <= sh_d;
      left_q      <= left_d;
      is_cmd_q    <= is_cmd_d;
      is_addr_q   <= is_addr_d;
      wait_q      <= wait_d;
      has_cmd_q   <= has_cmd_d;
      done        <= done_d;
      err         <= err_d;
      nand_ce_n   <= !bus_act_d;
      nand_cle    <= bus_act_d && is_cmd_d;
      nand_ale    <= bus_act_d && is_addr_d;
      nand_we_n   <= (state_d != ST_WLOW);
      nand_io_oe  <= bus_act_d;
      nand_io_out <= bus_act_d ? sh_d[7:0] : 8'h00;
    end
  end

  // Checker state: length of the current strobe-low run
  logic [CNT_W:0] low_run;
  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (nand_we_n) low_run <= '0;
    else low_run <= low_run + 1'b1;
  end

  AST_CMD_QUAL: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && nand_cle) |-> (!nand_ale && !nand_ce_n)); // R1
  AST_ADDR_QUAL: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && nand_ale) |-> (!nand_cle && !nand_ce_n)); // R2
  AST_WE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale))); // R4
  AST_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> (nand_io_oe && !nand_ce_n && $stable(nand_io_out))); // R4
  AST_WE_LOW_MAX: assert property (@(posedge clk) disable iff (rst)
    low_run <= (CNT_W+1)'(T_WLOW)); // R4
  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    nand_io_oe |-> !nand_ce_n); // R6
  AST_WE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_io_oe); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !nand_ce_n |-> !req_ready); // R7
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    err |-> (nand_ce_n && nand_we_n)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

endmodule

// File: tb/nand_bus_seq_bench.sv
module nand_bus_seq_bench;
  import nbs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_ADDR = 4;
  localparam int T_SETUP = 1;
  localparam int T_WLOW = 2;
  localparam int T_WHIGH = 2;
  localparam int T_BUSY_DLY = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_byte = 8'h00;
  logic [8*N_ADDR-1:0] req_addr = '0;
  logic req_wait = 1'b0;
  logic done, err;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out;
  logic nand_rdy = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  nand_bus_seq #(
    .N_ADDR(N_ADDR), .T_SETUP(T_SETUP), .T_WLOW(T_WLOW),
    .T_WHIGH(T_WHIGH), .T_BUSY_DLY(T_BUSY_DLY), .SYNC_STAGES(2)
  ) u_nand_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_byte(req_byte), .req_addr(req_addr),
    .req_wait(req_wait), .done(done), .err(err), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_rdy(nand_rdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Bus monitor, sampled on the falling clock edge
  int cyc = 0;
  logic prev_we = 1'b1;
  int lowlen = 0;
  int prelen = 0;
  int npulse = 0;
  int last_rise = 0;
  int done_cyc = 0;
  bit done_seen = 0;
  int err_seen = 0;
  logic [7:0] cap_io [64];
  logic cap_cle [64];
  logic cap_ale [64];
  logic cap_ce [64];
  logic cap_re [64];
  int cap_pre [64];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!nand_we_n) begin
        if (prev_we && npulse < 64) cap_pre[npulse] = prelen;
        lowlen++;
        prelen = 0;
        if (npulse < 64) begin
          cap_io[npulse]  = nand_io_out;
          cap_cle[npulse] = nand_cle;
          cap_ale[npulse] = nand_ale;
          cap_ce[npulse]  = nand_ce_n;
          cap_re[npulse]  = nand_re_n;
        end
      end else begin
        if (!prev_we) begin
          chk(lowlen == T_WLOW, "R4", "strobe low length", lowlen, T_WLOW);
          npulse++;
          last_rise = cyc;
        end
        lowlen = 0;
        if (nand_io_oe) prelen++;
        else prelen = 0;
      end
      if (done) begin
        done_seen = 1;
        done_cyc = cyc;
      end
      if (err) err_seen++;
    end
    prev_we = nand_we_n;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] b,
                      input logic [8*N_ADDR-1:0] a, input logic w);
    npulse = 0;
    done_seen = 0;
    while (!req_ready) step();
    req_valid = 1'b1;
    req_kind = k;
    req_byte = b;
    req_addr = a;
    req_wait = w;
    step();
    req_valid = 1'b0;
    req_wait = 1'b0;
  endtask

  task automatic wait_done(input string rq);
    int t = 0;
    while (!done_seen && t < 2000) begin
      step();
      t++;
    end
    chk(done_seen, rq, "done seen", done_seen, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) step();
    rst = 1'b0;
    step();
    // R11: reset state
    chk({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, req_ready, done, err}
        == 9'b1_0_0_1_1_0_1_0_0, "R11", "reset outputs",
        {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, req_ready, done, err},
        9'b100110100);

    // R8: data before any command
    err_seen = 0;
    send(2'd2, 8'hA5, '0, 1'b0);
    repeat (8) step();
    chk(err_seen == 1, "R8", "err pulse count", err_seen, 1);
    chk(npulse == 0, "R8", "strobe pulses on refused data", npulse, 0);
    chk(!done_seen, "R8", "done on refused data", done_seen, 0);

    // R1, R5, R10, R7, R6: sweep of every opcode
    for (int c = 0; c < 256; c++) begin
      send(2'd0, 8'(c), '0, 1'b0);
      chk(!req_ready, "R7", "ready while busy", req_ready, 0);
      wait_done("R10");
      chk(npulse == 1, "R1", "command pulse count", npulse, 1);
      chk(cap_io[0] == 8'(c) && cap_cle[0] && !cap_ale[0] && !cap_ce[0] && cap_re[0],
          "R1", "command cycle", {cap_ce[0], cap_cle[0], cap_ale[0], cap_re[0], cap_io[0]},
          {4'b0101, 8'(c)});
      chk(cap_pre[0] == T_SETUP, "R5", "command setup", cap_pre[0], T_SETUP);
      chk(done_cyc - last_rise == T_WHIGH, "R10", "done latency", done_cyc - last_rise, T_WHIGH);
      chk(!nand_io_oe && nand_ce_n, "R6", "bus released when idle", {nand_io_oe, nand_ce_n}, 2'b01);
    end

    // R2, R5: address groups, low byte first
    for (int p = 0; p < 12; p++) begin
      logic [31:0] av;
      case (p)
        0: av = 32'h0000_0000;
        1: av = 32'hFFFF_FFFF;
        2: av = 32'h1234_5678;
        3: av = 32'hA55A_C33C;
        default: av = 32'h0000_0001 << ((p - 4) * 4);
      endcase
      send(2'd1, 8'h00, av, 1'b0);
      wait_done("R2");
      chk(npulse == N_ADDR, "R2", "address pulse count", npulse, N_ADDR);
      for (int j = 0; j < N_ADDR; j++) begin
        chk(cap_io[j] == av[8*j +: 8] && cap_ale[j] && !cap_cle[j] && !cap_ce[j],
            "R2", "address cycle", {cap_ale[j], cap_cle[j], cap_io[j]}, {2'b10, av[8*j +: 8]});
        chk(cap_pre[j] == ((j == 0) ? T_SETUP : T_WHIGH + T_SETUP), "R5", "address gap",
            cap_pre[j], (j == 0) ? T_SETUP : T_WHIGH + T_SETUP);
      end
    end

    // R3: program data burst
    for (int i = 0; i < 16; i++) begin
      logic [7:0] dv;
      dv = 8'(i * 17 + 3);
      send((i % 2 == 0) ? 2'd2 : 2'd3, dv, '0, 1'b0);
      wait_done("R3");
      chk(npulse == 1 && cap_io[0] == dv && !cap_cle[0] && !cap_ale[0] && !cap_ce[0],
          "R3", "data cycle", {cap_cle[0], cap_ale[0], cap_io[0]}, {2'b00, dv});
    end

    // R9: wait with device already ready
    send(2'd0, 8'h10, '0, 1'b1);
    wait_done("R9");
    chk(done_cyc - last_rise == T_WHIGH + T_BUSY_DLY + 1, "R9", "wait latency ready",
        done_cyc - last_rise, T_WHIGH + T_BUSY_DLY + 1);

    // R9: wait with device busy for a long interval
    send(2'd0, 8'hD0, '0, 1'b1);
    nand_rdy = 1'b0;
    repeat (40) step();
    chk(!done_seen, "R9", "done while busy", done_seen, 0);
    nand_rdy = 1'b1;
    begin
      int raise_cyc;
      raise_cyc = cyc;
      wait_done("R9");
      chk(done_cyc - raise_cyc == 3, "R9", "done after ready rise", done_cyc - raise_cyc, 3);
    end

    repeat (4) step();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule